// File: doc/BRIEF.md
# Conditional Exclusive Store Unit

This block performs the conditional half of a load-linked / store-conditional pair against one local exclusive-access monitor. A load-exclusive request decodes the base register from an instruction word and arms the monitor with the byte range it covers. A later store-exclusive request writes its data to a simple valid/ready memory port only when the armed range still contains every byte of the store. In the cycle after the request, the block returns a one-bit result, zero-extended to 32 bits, for the status register named in the instruction.

The block takes the instruction word and the operand values already read from the register file: the base register, the stack pointer and the data register. A misaligned access raises a fault flag. When the status register index collides with the data or base register index, a two-bit policy input selects the outcome: substitute zero, flag the instruction as undefined, or treat it as a no-op. While a memory write waits for its handshake, the block shows busy and ignores new requests.

Top module: `sx_store_excl_unit`

## Requirements
- R1: Instruction bit 30 selects the access size: 0 gives a 4-byte access, 1 gives an 8-byte access. `mem_bytes` shows 4 or 8. A 4-byte store writes the low 32 bits of `data_val` with `mem_data[63:32]` zero.
- R2: The data register index is instruction bits 4:0, the base index is bits 9:5 and the status index is bits 20:16. `status_idx` returns bits 20:16 of the accepted request.
- R3: An executed, aligned store reports `status_data` = 0 and starts exactly one memory write when it passes. It reports 1 and starts no write when it fails. Bits 31:1 of `status_data` are always zero.
- R4: A store passes only if the monitor is armed and the range from its address to its address plus byte count minus 1 lies inside the armed range.
- R5: An address not aligned to its access size sets `align_fault`. Such a store writes no status and no memory. Such a load leaves the monitor unchanged.
- R6: A base index of 31 takes the address from `sp_val` instead of `base_val`, and the stack-pointer address is checked for alignment.
- R7: A store whose status index equals its data index follows `ovl_policy`. 0 stores zero data. 1 or 3 sets `undef_flag` with no status write and no memory write. 2 produces a response with no flag, no status write and no memory write.
- R8: A store whose status index equals its base index, with base index not 31, follows the same policy. 0 uses address zero. 1 or 3 means undefined. 2 means no-op. Status index and base index both 31 count as no collision.
- R9: The monitor is cleared by every store that executes (aligned or not, pass or fail) and by `mon_clear`. `mon_clear` wins over a load arming in the same cycle. Undefined and no-op stores leave the monitor unchanged.
- R10: A request is accepted when `req_valid` is high and `busy` is low. `resp_valid` and the status and flag outputs appear one cycle after acceptance. `mem_wr_valid` holds with stable address and data until `mem_wr_ready`. `busy` is high during that time, and requests made while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_store | input | 1 | 1 = store-exclusive, 0 = load-exclusive (arm) |
| req_instr | input | 32 | Instruction word carrying size and register fields |
| ovl_policy | input | 2 | Register-collision policy |
| base_val | input | AW | Value of the base register |
| sp_val | input | AW | Stack pointer value |
| data_val | input | 64 | Value of the data register |
| mon_clear | input | 1 | External monitor clear |
| busy | output | 1 | Memory write pending; requests ignored |
| resp_valid | output | 1 | One-cycle response pulse per accepted request |
| status_we | output | 1 | Status register write enable |
| status_idx | output | 5 | Status register index |
| status_data | output | 32 | Zero-extended status (0 success, 1 failure) |
| align_fault | output | 1 | Alignment fault |
| undef_flag | output | 1 | Instruction treated as undefined |
| mem_wr_valid | output | 1 | Memory write request |
| mem_wr_ready | input | 1 | Memory write accepted |
| mem_addr | output | AW | Write address |
| mem_data | output | 64 | Write data |
| mem_bytes | output | 4 | Write byte count (4 or 8) |

## Verification
The bench sweeps every pairing of arm offset, arm size, store offset and store size across a 16-byte window. A containment check that was off by one, or that compared only start addresses, would pass stores that hang over the armed range or reject stores that lie inside it. Directed cases cover each collision policy on both the data and the base register. A design that cleared the monitor on a no-op or undefined store would fail the follow-up store that ought to pass. One that let a base index of 31 count as a collision would flag an undefined instruction where none is due. Further cases cover an external clear arriving together with an arm, and a request sent while the write port is stalled. A design that let either of these through would pass a store that should fail.

// File: rtl/sx_pkg.sv
package sx_pkg;

    localparam logic [4:0] REG_SP = 5'd31;

    typedef enum logic [1:0] {
        POL_ZERO   = 2'd0,
        POL_UNDEF  = 2'd1,
        POL_NOP    = 2'd2,
        POL_UNDEF2 = 2'd3
    } ovl_pol_e;

    typedef enum logic [1:0] {
        ACT_EXEC  = 2'd0,
        ACT_UNDEF = 2'd1,
        ACT_NOP   = 2'd2
    } sx_act_e;

    typedef struct packed {
        logic       dbl;
        logic [4:0] rs;
        logic [4:0] rn;
        logic [4:0] rt;
    } sx_fields_t;

    function automatic logic [3:0] sx_nbytes(input logic dbl);
        return dbl ? 4'd8 : 4'd4;
    endfunction

    function automatic logic sx_misaligned(input logic [2:0] lo, input logic dbl);
        return dbl ? (lo != 3'd0) : (lo[1:0] != 2'd0);
    endfunction

endpackage

// File: rtl/sx_decode.sv
module sx_decode
    import sx_pkg::*;
#(
    parameter int AW = 64
) (
    input  logic [31:0]   instr,
    input  logic          is_store,
    input  logic [1:0]    policy,
    input  logic [AW-1:0] base_val,
    input  logic [AW-1:0] sp_val,
    input  logic [63:0]   data_val,
    output sx_act_e       act,
    output sx_fields_t    fld,
    output logic [AW-1:0] addr,
    output logic [63:0]   data,
    output logic          misaligned
);
    logic     unused_instr_bits;
    ovl_pol_e pol;
    logic     data_ovl, base_ovl, zero_data, zero_addr;
    logic [63:0] sized_data;

    assign unused_instr_bits = ^{instr[31], instr[29:21], instr[15:10]};

    always_comb begin
        fld.dbl = instr[30];
        fld.rs  = instr[20:16];
        fld.rn  = instr[9:5];
        fld.rt  = instr[4:0];
    end

    assign pol      = ovl_pol_e'(policy);
    assign data_ovl = is_store && (fld.rs == fld.rt);
    assign base_ovl = is_store && (fld.rs == fld.rn) && (fld.rn != REG_SP);

    always_comb begin
        act = ACT_EXEC;
        if (data_ovl || base_ovl) begin
            case (pol)
                POL_ZERO: act = ACT_EXEC;
                POL_NOP:  act = ACT_NOP;
                default:  act = ACT_UNDEF;
            endcase
        end
    end

    assign zero_data = data_ovl && (pol == POL_ZERO);
    assign zero_addr = base_ovl && (pol == POL_ZERO);

    assign sized_data = fld.dbl ? data_val : {32'd0, data_val[31:0]};
    assign data       = zero_data ? 64'd0 : sized_data;
    assign addr       = zero_addr ? '0 : ((fld.rn == REG_SP) ? sp_val : base_val);
    assign misaligned = sx_misaligned(addr[2:0], fld.dbl);

endmodule

// File: rtl/sx_monitor.sv
module sx_monitor
    import sx_pkg::*;
#(
    parameter int AW = 64
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          arm,
    input  logic [AW-1:0] arm_addr,
    input  logic          arm_dbl,
    input  logic          clr,
    input  logic [AW-1:0] chk_addr,
    input  logic          chk_dbl,
    output logic          hit
);
    localparam int XW = AW + 1;

    logic          mon_valid;
    logic [AW-1:0] mon_base;
    logic [3:0]    mon_len;
    logic [XW-1:0] chk_end, mon_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            mon_valid <= 1'b0;
            mon_base  <= '0;
            mon_len   <= 4'd0;
        end else if (clr) begin
            mon_valid <= 1'b0;
        end else if (arm) begin
            mon_valid <= 1'b1;
            mon_base  <= arm_addr;
            mon_len   <= sx_nbytes(arm_dbl);
        end
    end

    assign chk_end = {1'b0, chk_addr} + XW'(sx_nbytes(chk_dbl));
    assign mon_end = {1'b0, mon_base} + XW'(mon_len);
    assign hit     = mon_valid && (chk_addr >= mon_base) && (chk_end <= mon_end);

endmodule

// File: rtl/sx_wrport.sv
module sx_wrport
    import sx_pkg::*;
#(
    parameter int AW = 64
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          launch,
    input  logic [AW-1:0] addr,
    input  logic [63:0]   data,
    input  logic          dbl,
    input  logic          ready,
    output logic          wr_valid,
    output logic [AW-1:0] wr_addr,
    output logic [63:0]   wr_data,
    output logic [3:0]    wr_bytes
);
    always_ff @(posedge clk) begin
        if (rst) begin
            wr_valid <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= 64'd0;
            wr_bytes <= 4'd0;
        end else if (launch) begin
            wr_valid <= 1'b1;
            wr_addr  <= addr;
            wr_data  <= data;
            wr_bytes <= sx_nbytes(dbl);
        end else if (wr_valid && ready) begin
            wr_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/sx_store_excl_unit.sv
module sx_store_excl_unit
    import sx_pkg::*;
#(
    parameter int AW = 64
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic          req_store,
    input  logic [31:0]   req_instr,
    input  logic [1:0]    ovl_policy,
    input  logic [AW-1:0] base_val,
    input  logic [AW-1:0] sp_val,
    input  logic [63:0]   data_val,
    input  logic          mon_clear,
    output logic          busy,
    output logic          resp_valid,
    output logic          status_we,
    output logic [4:0]    status_idx,
    output logic [31:0]   status_data,
    output logic          align_fault,
    output logic          undef_flag,
    output logic          mem_wr_valid,
    input  logic          mem_wr_ready,
    output logic [AW-1:0] mem_addr,
    output logic [63:0]   mem_data,
    output logic [3:0]    mem_bytes
);
    sx_act_e       act;
    sx_fields_t    fld;
    logic [AW-1:0] eff_addr;
    logic [63:0]   eff_data;
    logic          mis, hit;
    logic          accept, st_exec, launch, arm, mon_clr;

    sx_decode #(.AW(AW)) u_dec (
        .instr      (req_instr),
        .is_store   (req_store),
        .policy     (ovl_policy),
        .base_val   (base_val),
        .sp_val     (sp_val),
        .data_val   (data_val),
        .act        (act),
        .fld        (fld),
        .addr       (eff_addr),
        .data       (eff_data),
        .misaligned (mis)
    );

    assign accept  = req_valid && !busy;
    assign st_exec = accept && req_store && (act == ACT_EXEC);
    assign launch  = st_exec && !mis && hit;
    assign arm     = accept && !req_store && !mis;
    assign mon_clr = mon_clear || st_exec;

    sx_monitor #(.AW(AW)) u_mon (
        .clk      (clk),
        .rst      (rst),
        .arm      (arm),
        .arm_addr (eff_addr),
        .arm_dbl  (fld.dbl),
        .clr      (mon_clr),
        .chk_addr (eff_addr),
        .chk_dbl  (fld.dbl),
        .hit      (hit)
    );

    sx_wrport #(.AW(AW)) u_wr (
        .clk      (clk),
        .rst      (rst),
        .launch   (launch),
        .addr     (eff_addr),
        .data     (eff_data),
        .dbl      (fld.dbl),
        .ready    (mem_wr_ready),
        .wr_valid (mem_wr_valid),
        .wr_addr  (mem_addr),
        .wr_data  (mem_data),
        .wr_bytes (mem_bytes)
    );

    assign busy = mem_wr_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_valid  <= 1'b0;
            status_we   <= 1'b0;
            status_idx  <= 5'd0;
            status_data <= 32'd0;
            align_fault <= 1'b0;
            undef_flag  <= 1'b0;
        end else begin
            resp_valid  <= accept;
            status_we   <= 1'b0;
            align_fault <= 1'b0;
            undef_flag  <= 1'b0;
            if (accept) begin
                status_idx <= fld.rs;
                if (!req_store) begin
                    align_fault <= mis;
                end else begin
                    case (act)
                        ACT_UNDEF: undef_flag <= 1'b1;
                        ACT_EXEC: begin
                            if (mis) begin
                                align_fault <= 1'b1;
                            end else begin
                                status_we   <= 1'b1;
                                status_data <= {31'd0, !hit};
                            end
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/sx_store_excl_chk.sv
module sx_store_excl_chk #(
    parameter int AW = 64
) (
    input logic          clk,
    input logic          rst,
    input logic          req_valid,
    input logic          busy,
    input logic          resp_valid,
    input logic          status_we,
    input logic [31:0]   status_data,
    input logic          align_fault,
    input logic          undef_flag,
    input logic          mem_wr_valid,
    input logic          mem_wr_ready,
    input logic [AW-1:0] mem_addr,
    input logic [63:0]   mem_data,
    input logic [3:0]    mem_bytes
);
    assert_resp_follows_req_R10: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy) |=> resp_valid);

    assert_no_resp_when_busy_R10: assert property (@(posedge clk) disable iff (rst)
        (!req_valid || busy) |=> !resp_valid);

    assert_write_held_R10: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_valid && !mem_wr_ready) |=> (mem_wr_valid && $stable(mem_addr) && $stable(mem_data)));

    assert_status_zext_R3: assert property (@(posedge clk) disable iff (rst)
        status_we |-> (status_data[31:1] == 31'd0));

    assert_write_means_success_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_wr_valid) |-> (status_we && !status_data[0]));

    assert_fail_no_write_R3: assert property (@(posedge clk) disable iff (rst)
        (status_we && status_data[0]) |-> !mem_wr_valid);

    assert_fault_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        align_fault |-> (!status_we && !mem_wr_valid));

    assert_undef_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        undef_flag |-> (!status_we && !mem_wr_valid));

    assert_aligned_write_R1: assert property (@(posedge clk) disable iff (rst)
        mem_wr_valid |-> ((mem_bytes == 4'd8 && mem_addr[2:0] == 3'd0) ||
                          (mem_bytes == 4'd4 && mem_addr[1:0] == 2'd0)));

    assert_word_upper_zero_R1: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_valid && mem_bytes == 4'd4) |-> (mem_data[63:32] == 32'd0));

endmodule

bind sx_store_excl_unit sx_store_excl_chk #(.AW(AW)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .busy         (busy),
    .resp_valid   (resp_valid),
    .status_we    (status_we),
    .status_data  (status_data),
    .align_fault  (align_fault),
    .undef_flag   (undef_flag),
    .mem_wr_valid (mem_wr_valid),
    .mem_wr_ready (mem_wr_ready),
    .mem_addr     (mem_addr),
    .mem_data     (mem_data),
    .mem_bytes    (mem_bytes)
);

// File: tb/tb_sx_store_excl_unit.sv
`timescale 1ns/1ps
module tb_sx_store_excl_unit;
    localparam int AW = 64;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0, req_store = 1'b0;
    logic [31:0]   req_instr = 32'd0;
    logic [1:0]    ovl_policy = 2'd0;
    logic [AW-1:0] base_val = '0, sp_val = '0;
    logic [63:0]   data_val = 64'd0;
    logic          mon_clear = 1'b0;
    logic          mem_wr_ready = 1'b1;
    logic          busy, resp_valid, status_we, align_fault, undef_flag, mem_wr_valid;
    logic [4:0]    status_idx;
    logic [31:0]   status_data;
    logic [AW-1:0] mem_addr;
    logic [63:0]   mem_data;
    logic [3:0]    mem_bytes;

    int n_chk = 0, n_fail = 0, cyc = 0;
    logic done = 1'b0;

    logic          g_resp, g_swe, g_flt, g_und, g_wv;
    logic [31:0]   g_sd;
    logic [4:0]    g_idx;
    logic [AW-1:0] g_addr;
    logic [63:0]   g_data;
    logic [3:0]    g_bytes;

    always #2 clk = ~clk;

    sx_store_excl_unit #(.AW(AW)) dut (.*);

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            summary();
        end
    end

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic dbl, input logic [4:0] s, input logic [4:0] n, input logic [4:0] t);
        return {1'b1, dbl, 9'd0, s, 6'd0, n, t};
    endfunction

    task automatic issue(input logic st, input logic [4:0] s, input logic [4:0] n, input logic [4:0] t,
                         input logic dbl, input logic [63:0] base, input logic [63:0] sp,
                         input logic [63:0] d, input logic [1:0] pol);
        @(negedge clk);
        req_store = st; req_instr = mk(dbl, s, n, t); base_val = base; sp_val = sp;
        data_val = d; ovl_policy = pol; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        g_resp = resp_valid; g_swe = status_we; g_sd = status_data; g_idx = status_idx;
        g_flt = align_fault; g_und = undef_flag; g_wv = mem_wr_valid;
        g_addr = mem_addr; g_data = mem_data; g_bytes = mem_bytes;
        if (mem_wr_valid && mem_wr_ready) @(negedge clk);
    endtask

    task automatic arm_at(input logic [63:0] a, input logic dbl);
        issue(1'b0, 5'd0, 5'd2, 5'd1, dbl, a, 64'd0, 64'd0, 2'd0);
    endtask

    task automatic store_at(input logic [63:0] a, input logic dbl, input logic [63:0] d);
        issue(1'b1, 5'd3, 5'd2, 5'd1, dbl, a, 64'd0, d, 2'd0);
    endtask

    function automatic logic al(input logic [63:0] a, input logic dbl);
        return dbl ? (a[2:0] == 3'd0) : (a[1:0] == 2'd0);
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R10 reset state
        check("R10 reset busy", busy, 0);
        check("R10 reset resp", resp_valid, 0);
        check("R3 reset status_we", status_we, 0);
        check("R3 reset write", mem_wr_valid, 0);

        // R4 store with nothing armed
        store_at(64'h800, 1'b1, 64'h1);
        check("R4 unarmed store status", g_sd, 32'd1);
        check("R3 unarmed no write", g_wv, 0);

        // R4 R5 R1 R2 R3 sweep
        for (int sa = 0; sa < 2; sa++)
            for (int ao = 0; ao < 16; ao++)
                for (int ss = 0; ss < 2; ss++)
                    for (int so = 0; so < 16; so++) begin
                        logic [63:0] a, s, d;
                        logic pass, a_ok, s_ok;
                        a = 64'h1000 + 64'(ao);
                        s = 64'h1000 + 64'(so);
                        d = 64'hA5C3_0F0F_0000_0000 | 64'(ao * 37 + so * 5 + ss);
                        a_ok = al(a, sa[0]);
                        s_ok = al(s, ss[0]);
                        pass = a_ok && s_ok && (s >= a) &&
                               (s + (ss[0] ? 8 : 4) <= a + (sa[0] ? 8 : 4));
                        arm_at(a, sa[0]);
                        check("R5 load alignment fault", g_flt, !a_ok);
                        store_at(s, ss[0], d);
                        check("R10 response", g_resp, 1);
                        if (!s_ok) begin
                            check("R5 store fault", g_flt, 1);
                            check("R5 fault no status", g_swe, 0);
                            check("R5 fault no write", g_wv, 0);
                        end else begin
                            check("R3 status written", g_swe, 1);
                            check("R4 status value", g_sd, {63'd0, !pass});
                            check("R3 write iff pass", g_wv, pass);
                            check("R2 status index", g_idx, 5'd3);
                            if (pass) begin
                                check("R1 address", g_addr, s);
                                check("R1 bytes", g_bytes, ss[0] ? 8 : 4);
                                check("R1 data", g_data, ss[0] ? d : {32'd0, d[31:0]});
                            end
                        end
                    end

        // R6 stack pointer base
        issue(1'b0, 5'd0, 5'd31, 5'd1, 1'b1, 64'hBAD1, 64'h2000, 64'd0, 2'd0);
        check("R6 sp arm no fault", g_flt, 0);
        issue(1'b1, 5'd4, 5'd31, 5'd1, 1'b1, 64'hBAD1, 64'h2000, 64'h55, 2'd0);
        check("R6 sp store status", g_sd, 32'd0);
        check("R6 sp address", g_addr, 64'h2000);
        issue(1'b1, 5'd4, 5'd31, 5'd1, 1'b1, 64'h3000, 64'h2004, 64'h55, 2'd0);
        check("R6 sp misaligned fault", g_flt, 1);

        // R8 status and base both 31: no collision
        issue(1'b0, 5'd0, 5'd31, 5'd1, 1'b1, 64'd0, 64'h5000, 64'd0, 2'd0);
        issue(1'b1, 5'd31, 5'd31, 5'd1, 1'b1, 64'hBAD1, 64'h5000, 64'h77, 2'd1);
        check("R8 s=n=31 no undef", g_und, 0);
        check("R8 s=n=31 executes", g_sd, 32'd0);
        check("R2 s=n=31 index", g_idx, 5'd31);

        // R7 data collision, policy 0
        arm_at(64'h3000, 1'b1);
        issue(1'b1, 5'd4, 5'd2, 5'd4, 1'b1, 64'h3000, 64'd0, 64'hFFFF_FFFF_FFFF_FFFF, 2'd0);
        check("R7 zero data status", g_sd, 32'd0);
        check("R7 zero data value", g_data, 64'd0);
        // R7 policy 1 and 3: undefined, monitor kept (R9)
        for (int p = 1; p < 4; p += 2) begin
            arm_at(64'h3000, 1'b1);
            issue(1'b1, 5'd4, 5'd2, 5'd4, 1'b1, 64'h3000, 64'd0, 64'h9, 2'(p));
            check("R7 undef flag", g_und, 1);
            check("R7 undef no status", g_swe, 0);
            check("R7 undef no write", g_wv, 0);
            store_at(64'h3000, 1'b1, 64'h1);
            check("R9 undef keeps monitor", g_sd, 32'd0);
        end
        // R7 policy 2: no-op
        arm_at(64'h3000, 1'b1);
        issue(1'b1, 5'd4, 5'd2, 5'd4, 1'b1, 64'h3000, 64'd0, 64'h9, 2'd2);
        check("R7 nop response", g_resp, 1);
        check("R7 nop no flags", {g_und, g_flt, g_swe, g_wv}, 4'd0);
        store_at(64'h3000, 1'b1, 64'h1);
        check("R9 nop keeps monitor", g_sd, 32'd0);

        // R8 base collision
        arm_at(64'd0, 1'b1);
        issue(1'b1, 5'd2, 5'd2, 5'd1, 1'b1, 64'h7777, 64'd0, 64'hABCD, 2'd0);
        check("R8 zero address status", g_sd, 32'd0);
        check("R8 zero address", g_addr, 64'd0);
        arm_at(64'h3000, 1'b0);
        issue(1'b1, 5'd2, 5'd2, 5'd1, 1'b0, 64'h3000, 64'd0, 64'h1, 2'd1);
        check("R8 undef flag", g_und, 1);
        check("R8 undef no write", g_wv, 0);
        issue(1'b1, 5'd2, 5'd2, 5'd1, 1'b0, 64'h3000, 64'd0, 64'h1, 2'd2);
        check("R8 nop quiet", {g_und, g_swe, g_wv}, 3'd0);

        // R9 clear behaviour
        arm_at(64'h4000, 1'b1);
        @(negedge clk); mon_clear = 1'b1; @(negedge clk); mon_clear = 1'b0;
        store_at(64'h4000, 1'b1, 64'h1);
        check("R9 external clear", g_sd, 32'd1);
        @(negedge clk);
        req_store = 1'b0; req_instr = mk(1'b1, 5'd0, 5'd2, 5'd1); base_val = 64'h4000;
        req_valid = 1'b1; mon_clear = 1'b1;
        @(negedge clk); req_valid = 1'b0; mon_clear = 1'b0;
        store_at(64'h4000, 1'b1, 64'h1);
        check("R9 clear beats arm", g_sd, 32'd1);
        arm_at(64'h4000, 1'b1);
        store_at(64'h4000, 1'b1, 64'h1);
        check("R9 first store passes", g_sd, 32'd0);
        store_at(64'h4000, 1'b1, 64'h1);
        check("R9 second store fails", g_sd, 32'd1);
        arm_at(64'h4000, 1'b1);
        store_at(64'h4001, 1'b1, 64'h1);
        check("R5 misaligned store fault", g_flt, 1);
        store_at(64'h4000, 1'b1, 64'h1);
        check("R9 faulting store cleared", g_sd, 32'd1);

        // R10 stall and busy
        arm_at(64'h6000, 1'b1);
        @(negedge clk); mem_wr_ready = 1'b0;
        store_at(64'h6000, 1'b1, 64'h1234);
        check("R10 write raised", g_wv, 1);
        @(negedge clk); @(negedge clk);
        check("R10 held valid", mem_wr_valid, 1);
        check("R10 busy", busy, 1);
        check("R10 held address", mem_addr, 64'h6000);
        req_store = 1'b0; req_instr = mk(1'b1, 5'd0, 5'd2, 5'd1); base_val = 64'h7000; req_valid = 1'b1;
        @(negedge clk); req_valid = 1'b0;
        check("R10 request ignored", resp_valid, 0);
        mem_wr_ready = 1'b1;
        @(negedge clk);
        check("R10 write released", mem_wr_valid, 0);
        check("R10 not busy", busy, 0);
        store_at(64'h7000, 1'b1, 64'h1);
        check("R10 ignored load did not arm", g_sd, 32'd1);

        done = 1'b1;
        summary();
    end
endmodule